// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block decides which received teletext pages to capture. A host loads a small request store that has one row of seven 5-bit entries for each acquisition circuit. Each entry pairs a digit of the wanted page with a care bit. Column 0 holds the magazine and a hold flag. Columns 1 and 2 hold the page tens and units. Columns 3 to 6 hold the hours tens, hours units, minutes tens and minutes units of the time sub-code. Because every digit has its own care bit, the same mechanism serves plain page requests and timed page requests.

For each decoded header presented with its per-field Hamming error flags, every circuit compares the header against its row. The lowest-numbered circuit that is allowed to capture wins. One cycle later the block raises a single-cycle capture strobe with the target chapter, formed from a bank bit and the winning circuit index. For each circuit it also reports two flags for the row-25 control bytes: an active-low found flag and a still-searching flag.

Top module: `pgreq_match`

## Requirements
- R1: After reset, `cap_stb_o` is 0, every `found_n_o` bit is 1 and every `pblf_o` bit is 0.
- R2: A cycle with `wr_start_i` high loads circuit `wr_circ_i` and column `wr_col_i` into the write pointer, and that same cycle's `wr_en_i` write goes there. Each `wr_en_i` cycle stores `wr_data_i` at the pointer and advances the column. After column 6 the column wraps to 0.
- R3: An entry's care bit is bit 4. When the care bit is 0, that column matches any header value. When it is 1, only the low field bits are compared: 3 bits for the magazine (column 0), 4 bits for the page tens, 2 bits for the hours tens, 3 bits for the minutes tens, and 4 bits for every other column. Bit 3 of column 0 is the hold flag and is never compared.
- R4: A set error flag (`hdr_err_i` bit k for column k) prevents a match when column k's care bit is 1. It has no effect when that care bit is 0.
- R5: A header presented with `hdr_valid_i` in cycle n that produces a capture gives `cap_stb_o` high in cycle n+1 only. In that cycle `cap_chap_o` equals {`bank_i`, circuit index}.
- R6: When several circuits match the same header, only the lowest index captures. The other circuits keep their state.
- R7: A circuit never written since reset never captures.
- R8: Any write to a circuit puts it into search: its `pblf_o` bit becomes 1 and its `found_n_o` bit becomes 1.
- R9: A capture drives the winning circuit's `found_n_o` bit to 0 and its `pblf_o` bit to 0.
- R10: In a found circuit, the hold flag at 0 (column 0 bit 3) blocks any further capture. The hold flag at 1 lets the circuit capture again on later matches.
- R11: No capture strobe is produced in any cycle that follows one with `hdr_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start_i | input | 1 | Load the write pointer from `wr_circ_i` and `wr_col_i` |
| wr_circ_i | input | 2 | Acquisition circuit to write |
| wr_col_i | input | 3 | Starting column, 0 to 6 |
| wr_en_i | input | 1 | Store `wr_data_i` and advance the column |
| wr_data_i | input | 5 | Request entry: care bit in bit 4, digit in bits 3:0 |
| bank_i | input | 1 | Chapter bank bit |
| hdr_valid_i | input | 1 | Header fields are valid this cycle |
| hdr_digits_i | input | 28 | Decoded header digits; column k in bits 4k+3:4k |
| hdr_err_i | input | 7 | Hamming error flag for each column |
| cap_stb_o | output | 1 | Single-cycle capture strobe |
| cap_chap_o | output | 3 | Target chapter of the capture |
| found_n_o | output | 4 | Active-low found flag for each circuit |
| pblf_o | output | 4 | Still-searching flag for each circuit |

## Verification
The assertions assume that `hdr_valid_i` and both write controls are driven to known values from reset. They also assume the starting column never exceeds 6. The bench never drives column 7, even though the RTL folds it to 0. The stimulus changes inputs only on falling edges and keeps header cycles apart from write cycles, so the comparison always uses settled request contents. The sweeps vary one header column at a time through all 16 values and compute the expected match from the field width of that column.

// File: rtl/pgreq_pkg.sv
package pgreq_pkg;
   localparam int COLS     = 7;
   localparam int DIG_W    = 5;
   localparam int NIB_W    = 4;
   localparam int CARE_BIT = 4;
   localparam int HOLD_BIT = 3;
   localparam int COL_W    = 3;

   typedef logic [DIG_W-1:0] req_entry_t;

   // compared bits of each request column
   function automatic logic [NIB_W-1:0] col_mask(input int k);
      case (k)
         0:       col_mask = 4'b0111;
         3:       col_mask = 4'b0011;
         5:       col_mask = 4'b0111;
         default: col_mask = 4'b1111;
      endcase
   endfunction
endpackage

// File: rtl/pgreq_wrptr.sv
module pgreq_wrptr
   import pgreq_pkg::*;
#(
   parameter int NUM_CIRC = 4,
   localparam int CIRC_W = $clog2(NUM_CIRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start_i,
   input  logic [CIRC_W-1:0] wr_circ_i,
   input  logic [COL_W-1:0]  wr_col_i,
   input  logic              wr_en_i,
   output logic [CIRC_W-1:0] sel_circ_o,
   output logic [COL_W-1:0]  sel_col_o
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

   logic [CIRC_W-1:0] circ_q;
   logic [COL_W-1:0]  col_q;
   logic [COL_W-1:0]  start_col;
   logic [COL_W-1:0]  next_col;

   always_comb begin
      start_col  = (wr_col_i > LAST_COL) ? '0 : wr_col_i;
      sel_circ_o = wr_start_i ? wr_circ_i : circ_q;
      sel_col_o  = wr_start_i ? start_col : col_q;
      next_col   = (sel_col_o == LAST_COL) ? '0 : sel_col_o + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         circ_q <= '0;
         col_q  <= '0;
      end else if (wr_start_i || wr_en_i) begin
         circ_q <= sel_circ_o;
         col_q  <= wr_en_i ? next_col : sel_col_o;
      end
   end

   p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= LAST_COL);

   p_col_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_start_i && col_q == LAST_COL) |=> (col_q == '0));
endmodule

// File: rtl/pgreq_circuit.sv
module pgreq_circuit
   import pgreq_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en_i,
   input  logic [COL_W-1:0]       wr_col_i,
   input  req_entry_t             wr_data_i,
   input  logic                   hdr_valid_i,
   input  logic [COLS*NIB_W-1:0]  hdr_digits_i,
   input  logic [COLS-1:0]        hdr_err_i,
   input  logic                   grant_i,
   output logic                   req_o,
   output logic                   pblf_o,
   output logic                   found_n_o
);
   req_entry_t      ram_q [COLS];
   logic [COLS-1:0] col_ok;
   logic            search_q;
   logic            found_q;
   logic            may_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < COLS; k++) ram_q[k] <= '0;
      end else if (wr_en_i) begin
         ram_q[wr_col_i] <= wr_data_i;
      end
   end

   for (genvar k = 0; k < COLS; k++) begin : g_col
      localparam logic [NIB_W-1:0] MASK = col_mask(k);
      logic [NIB_W-1:0] diff;
      assign diff = (ram_q[k][NIB_W-1:0] ^ hdr_digits_i[k*NIB_W +: NIB_W]) & MASK;
      assign col_ok[k] = !ram_q[k][CARE_BIT] || (!hdr_err_i[k] && diff == '0);
   end

   assign may_cap = search_q || (found_q && ram_q[0][HOLD_BIT]);
   assign req_o   = hdr_valid_i && (&col_ok) && may_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         search_q <= 1'b0;
         found_q  <= 1'b0;
      end else if (wr_en_i) begin
         search_q <= 1'b1;
         found_q  <= 1'b0;
      end else if (grant_i) begin
         search_q <= 1'b0;
         found_q  <= 1'b1;
      end
   end

   assign pblf_o    = search_q;
   assign found_n_o = ~found_q;

   p_found_by_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found_q) |-> $past(grant_i));

   p_state_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(found_q && search_q));

   p_grant_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> req_o);
endmodule

// File: rtl/pgreq_arbiter.sv
module pgreq_arbiter #(
   parameter int NUM_CIRC = 4,
   localparam int CIRC_W = $clog2(NUM_CIRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hdr_valid_i,
   input  logic                bank_i,
   input  logic [NUM_CIRC-1:0] req_i,
   output logic [NUM_CIRC-1:0] grant_o,
   output logic                cap_stb_o,
   output logic [CIRC_W:0]     cap_chap_o
);
   logic [CIRC_W-1:0] win_idx;
   logic              hit;

   always_comb begin
      grant_o = '0;
      win_idx = '0;
      hit     = 1'b0;
      for (int i = 0; i < NUM_CIRC; i++) begin
         if (req_i[i] && !hit) begin
            grant_o[i] = 1'b1;
            win_idx    = CIRC_W'(i);
            hit        = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_stb_o  <= 1'b0;
         cap_chap_o <= '0;
      end else begin
         cap_stb_o <= hdr_valid_i && hit;
         if (hit) cap_chap_o <= {bank_i, win_idx};
      end
   end

   p_cap_needs_hdr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb_o |-> $past(hdr_valid_i));

   p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
endmodule

// File: rtl/pgreq_match.sv
module pgreq_match
   import pgreq_pkg::*;
#(
   parameter int NUM_CIRC = 4,
   localparam int CIRC_W = $clog2(NUM_CIRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_start_i,
   input  logic [CIRC_W-1:0]      wr_circ_i,
   input  logic [COL_W-1:0]       wr_col_i,
   input  logic                   wr_en_i,
   input  logic [DIG_W-1:0]       wr_data_i,
   input  logic                   bank_i,
   input  logic                   hdr_valid_i,
   input  logic [COLS*NIB_W-1:0]  hdr_digits_i,
   input  logic [COLS-1:0]        hdr_err_i,
   output logic                   cap_stb_o,
   output logic [CIRC_W:0]        cap_chap_o,
   output logic [NUM_CIRC-1:0]    found_n_o,
   output logic [NUM_CIRC-1:0]    pblf_o
);
   if (NUM_CIRC < 2 || (NUM_CIRC & (NUM_CIRC - 1)) != 0) begin : g_bad_circ
      $error("NUM_CIRC must be a power of two, at least 2");
   end

   logic [CIRC_W-1:0]   sel_circ;
   logic [COL_W-1:0]    sel_col;
   logic [NUM_CIRC-1:0] req;
   logic [NUM_CIRC-1:0] grant;

   pgreq_wrptr #(.NUM_CIRC(NUM_CIRC)) u_wrptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start_i (wr_start_i),
      .wr_circ_i  (wr_circ_i),
      .wr_col_i   (wr_col_i),
      .wr_en_i    (wr_en_i),
      .sel_circ_o (sel_circ),
      .sel_col_o  (sel_col)
   );

   for (genvar i = 0; i < NUM_CIRC; i++) begin : g_circ
      logic wr_here;
      assign wr_here = wr_en_i && (sel_circ == CIRC_W'(i));

      pgreq_circuit u_circ (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_en_i      (wr_here),
         .wr_col_i     (sel_col),
         .wr_data_i    (wr_data_i),
         .hdr_valid_i  (hdr_valid_i),
         .hdr_digits_i (hdr_digits_i),
         .hdr_err_i    (hdr_err_i),
         .grant_i      (grant[i]),
         .req_o        (req[i]),
         .pblf_o       (pblf_o[i]),
         .found_n_o    (found_n_o[i])
      );
   end

   pgreq_arbiter #(.NUM_CIRC(NUM_CIRC)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .hdr_valid_i (hdr_valid_i),
      .bank_i      (bank_i),
      .req_i       (req),
      .grant_o     (grant),
      .cap_stb_o   (cap_stb_o),
      .cap_chap_o  (cap_chap_o)
   );

   p_idle_after_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb_o && $past(pblf_o) == '0) |-> ($past(found_n_o) != '1));
endmodule

// File: tb/pgreq_match_bench.sv
`timescale 1ns/1ps
module pgreq_match_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 1'b0;
   logic [1:0]  wr_circ = '0;
   logic [2:0]  wr_col = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_data = '0;
   logic        bank = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [27:0] hdr_digits = '0;
   logic [6:0]  hdr_err = '0;
   logic        cap_stb;
   logic [2:0]  cap_chap;
   logic [3:0]  found_n;
   logic [3:0]  pblf;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pgreq_match u_pgreq_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_start_i   (wr_start),
      .wr_circ_i    (wr_circ),
      .wr_col_i     (wr_col),
      .wr_en_i      (wr_en),
      .wr_data_i    (wr_data),
      .bank_i       (bank),
      .hdr_valid_i  (hdr_valid),
      .hdr_digits_i (hdr_digits),
      .hdr_err_i    (hdr_err),
      .cap_stb_o    (cap_stb),
      .cap_chap_o   (cap_chap),
      .found_n_o    (found_n),
      .pblf_o       (pblf)
   );

   task automatic chk(input int act, input int exp, input string tag);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_start = 0; wr_en = 0; hdr_valid = 0; hdr_err = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // data holds up to 7 entries, entry j in bits 5j+4:5j
   task automatic wr_seq(input int circ, input int col, input int n, input logic [34:0] data);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         wr_start = (j == 0);
         wr_circ  = 2'(circ);
         wr_col   = 3'(col);
         wr_en    = 1'b1;
         wr_data  = data[5*j +: 5];
      end
      @(negedge clk);
      wr_start = 1'b0;
      wr_en    = 1'b0;
   endtask

   task automatic send_hdr(input logic [27:0] dig, input logic [6:0] err, input logic vld,
                           output logic stb, output logic [2:0] chap);
      @(negedge clk);
      hdr_valid  = vld;
      hdr_digits = dig;
      hdr_err    = err;
      @(negedge clk);
      hdr_valid = 1'b0;
      hdr_err   = '0;
      stb  = cap_stb;
      chap = cap_chap;
   endtask

   function automatic logic [27:0] pk(input int a0, a1, a2, a3, a4, a5, a6);
      pk = {4'(a6), 4'(a5), 4'(a4), 4'(a3), 4'(a2), 4'(a1), 4'(a0)};
   endfunction

   initial begin
      #1000000;
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic       stb;
      logic [2:0] chap;
      int rq [7] = '{3, 7, 9, 2, 5, 4, 8};
      int wd [7] = '{3, 4, 4, 2, 4, 3, 4};
      logic [27:0] base;

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk(cap_stb, 0, "R1 cap_stb");
      chk(found_n, 4'hF, "R1 found_n");
      chk(pblf, 0, "R1 pblf");

      // R7 idle circuits never capture
      send_hdr(pk(0,0,0,0,0,0,0), 7'h0, 1'b1, stb, chap);
      chk(stb, 0, "R7 idle no capture");

      // R8 write puts circuit 2 in search; care=1 hold=1 mag=5
      bank = 1'b1;
      wr_seq(2, 0, 1, 35'(5'b11101));
      chk(pblf, 4'b0100, "R8 pblf after write");
      chk(found_n, 4'hF, "R8 found_n after write");

      // R3 magazine sweep, bit 3 of column 0 not compared
      for (int v = 0; v < 16; v++) begin
         send_hdr(pk(v, 1, 2, 3, 4, 5, 6), 7'h0, 1'b1, stb, chap);
         chk(stb, ((v & 7) == 5) ? 1 : 0, "R3 magazine sweep");
         if ((v & 7) == 5) chk(chap, 3'b110, "R5 chapter bank1 circ2");
      end
      chk(found_n, 4'b1011, "R9 found_n after capture");
      chk(pblf, 4'b0000, "R9 pblf after capture");

      // R2 wrapping write: start col 5, seven entries, all cared
      do_reset();
      bank = 1'b0;
      wr_seq(1, 5, 7, {5'b10101, 5'b10010, 5'b11001, 5'b10111, 5'b11011, 5'b11000, 5'b10100});
      base = pk(3, 7, 9, 2, 5, 4, 8);
      send_hdr(base, 7'h0, 1'b1, stb, chap);
      chk(stb, 1, "R2 wrapped row matches");
      chk(chap, 3'b001, "R5 chapter bank0 circ1");
      @(negedge clk);
      chk(cap_stb, 0, "R5 strobe lasts one cycle");

      // R3 per-column sweep against field widths
      for (int k = 0; k < 7; k++) begin
         for (int v = 0; v < 16; v++) begin
            logic [27:0] d;
            int m;
            d = base;
            d[4*k +: 4] = 4'(v);
            m = (1 << wd[k]) - 1;
            send_hdr(d, 7'h0, 1'b1, stb, chap);
            chk(stb, (((v ^ rq[k]) & m) == 0) ? 1 : 0, "R3 column sweep");
         end
      end

      // R4 error flag on cared column blocks match
      for (int k = 0; k < 7; k++) begin
         send_hdr(base, 7'(1 << k), 1'b1, stb, chap);
         chk(stb, 0, "R4 error on cared column");
      end
      wr_seq(1, 3, 1, 35'(5'b00010));
      chk(pblf, 4'b0010, "R8 rewrite re-enters search");
      send_hdr(pk(3, 7, 9, 0, 5, 4, 8), 7'b0001000, 1'b1, stb, chap);
      chk(stb, 1, "R4 error on uncared column ignored");

      // R6 priority among circuits 1 and 3 (care off everywhere)
      do_reset();
      bank = 1'b1;
      wr_seq(3, 0, 1, 35'(5'b01000));
      wr_seq(1, 0, 1, 35'(5'b01000));
      send_hdr(pk(1, 2, 3, 0, 4, 5, 6), 7'h0, 1'b1, stb, chap);
      chk(stb, 1, "R6 capture with two matches");
      chk(chap, 3'b101, "R6 lowest index wins");
      chk(found_n, 4'b1101, "R6 loser keeps found_n");
      chk(pblf, 4'b1000, "R6 loser keeps pblf");
      send_hdr(pk(2, 2, 3, 0, 4, 5, 6), 7'h0, 1'b1, stb, chap);
      chk(chap, 3'b101, "R10 hold high recaptures");

      // R10 hold low freezes a found page
      do_reset();
      bank = 1'b0;
      wr_seq(0, 0, 1, 35'(5'b10010));
      send_hdr(pk(2, 0, 0, 0, 0, 0, 0), 7'h0, 1'b1, stb, chap);
      chk(stb, 1, "R10 first capture");
      chk(chap, 3'b000, "R5 chapter bank0 circ0");
      send_hdr(pk(2, 0, 0, 0, 0, 0, 0), 7'h0, 1'b1, stb, chap);
      chk(stb, 0, "R10 held page not recaptured");
      chk(found_n, 4'b1110, "R10 found_n held");
      send_hdr(pk(3, 0, 0, 0, 0, 0, 0), 7'h0, 1'b1, stb, chap);
      chk(stb, 0, "R3 magazine mismatch");
      wr_seq(0, 0, 1, 35'(5'b10010));
      chk(pblf, 4'b0001, "R8 rewrite after found");
      chk(found_n, 4'hF, "R8 found_n cleared by write");

      // R11 no capture without valid
      for (int t = 0; t < 3; t++) begin
         send_hdr(pk(2, 0, 0, 0, 0, 0, 0), 7'h0, 1'b0, stb, chap);
         chk(stb, 0, "R11 no valid no capture");
      end
      chk(pblf, 4'b0001, "R11 state untouched");
      send_hdr(pk(2, 0, 0, 0, 0, 0, 0), 7'h0, 1'b1, stb, chap);
      chk(stb, 1, "R8 search capture after rewrite");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule